// File: doc/BRIEF.md
# Pipelined Byte-Write SRAM with Double-Cycle Deselect

A single-clock synchronous memory. Address, write data, the three chip selects, the write controls and the snooze input are all captured on the rising clock edge. A captured read returns its word one registered stage later. A captured write is merged into the array at the following edge, with no external write-pulse timing. Writes are done per lane; a lane is one data byte plus its parity bit. A global write forces every lane.

The data bus is split into a write-data input, a read-data output and a drive-enable output, so that a pad ring can build the shared bidirectional bus from them. The drive enable is gated directly, with no clock involved, by the active-low output enable and by the snooze input. After a read, a deselect keeps the driver on for one extra cycle. This lets several banks share one bus in depth without a turnaround bubble.

Addresses come from an external burst sequencer, one per cycle. The asynchronous reset is released through a two-stage synchronizer.

Top module: `ssram_dcd_top`

## Requirements
- R1: While reset is held, and after it is released with no read issued, `rdata_oe` is 0.
- R2: A selected read captured at edge k drives the stored word on `rdata` with `rdata_oe` = 1 after edge k+1. Back-to-back reads stream one word per cycle.
- R3: With `gwr_n` = 1 and `bwr_master_n` = 0, lane i (bits i*9 .. i*9+8, with the parity bit as the top bit) is written when `lane_wr_n[i]` = 0. Lanes whose bit is 1 keep their contents.
- R4: With `gwr_n` = 0, every lane is written whatever `bwr_master_n` and `lane_wr_n` are.
- R5: With `gwr_n` = 1 and `bwr_master_n` = 1, the cycle is a read and `lane_wr_n` has no effect.
- R6: The block is selected only when `cs_n` = 0, `cs_hi` = 1 and `cs_lo_n` = 0. Any other combination performs no read and no write.
- R7: When a read is followed by a deselect, `rdata_oe` stays 1 with the same `rdata` for one more cycle (after edge k+2), then drops to 0 after edge k+3.
- R8: `oe_n` = 1 forces `rdata_oe` to 0 at once, with no clock edge. Returning it to 0 restores the drive.
- R9: While `snooze` = 1, `rdata_oe` is 0 at once, and cycles captured with `snooze` = 1 neither read nor write.
- R10: A read captured in the cycle right after a write to the same address returns the newly written data.
- R11: A write cycle that follows a read turns the driver off after the next edge (no extra hold cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| cs_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Expansion select, active high |
| cs_lo_n | input | 1 | Expansion select, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_master_n | input | 1 | Qualifier for the lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Standby; blocks accesses and the driver |
| rdata | output | LANES*LANE_W | Read data |
| rdata_oe | output | 1 | Data bus drive enable |

## Verification
Every address is first filled through global writes and then streamed back with continuous reads. This separates addressing faults from latency faults. All four lane masks are then applied to one word: the master-qualified writes show lane isolation, and the global write with no lanes enabled shows the override. A cycle with both write controls inactive but the lane bits low must read, which exposes any write leaking through. All seven non-selecting chip-select combinations try to overwrite a known word. The read–deselect, read–write and read–read orders separate the extra hold cycle from ordinary drive timing. Output enable and snooze are toggled in the middle of a cycle to show that they gate the driver without a clock.

// File: rtl/ssram_dcd_pkg.sv
package ssram_dcd_pkg;
  // decoded access captured at the input stage
  typedef struct packed {
    logic rd;
    logic wr;
    logic desel;
  } ssram_cmd_t;
endpackage

// File: rtl/ssram_cmd_reg.sv
module ssram_cmd_reg
  import ssram_dcd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      cs_n,
  input  logic                      cs_hi,
  input  logic                      cs_lo_n,
  input  logic                      gwr_n,
  input  logic                      bwr_master_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic                      snooze,
  output ssram_cmd_t                cmd_q,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [LANES*LANE_W-1:0]   wdata_q,
  output logic [LANES-1:0]          lane_we_q
);
  localparam int DW = LANES * LANE_W;

  ssram_cmd_t       cmd_d;
  logic [LANES-1:0] lane_we_d;
  logic             sel;
  logic             wr_any;

  always_comb begin
    sel       = !cs_n && cs_hi && !cs_lo_n && !snooze;
    wr_any    = !gwr_n || !bwr_master_n;
    if (!gwr_n)             lane_we_d = {LANES{1'b1}};
    else if (!bwr_master_n) lane_we_d = ~lane_wr_n;
    else                    lane_we_d = '0;
    cmd_d.rd    = sel && !wr_any;
    cmd_d.wr    = sel && wr_any;
    cmd_d.desel = !sel;
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '{rd: 1'b0, wr: 1'b0, desel: 1'b1};
      lane_we_q <= '0;
    end else begin
      cmd_q     <= cmd_d;
      lane_we_q <= lane_we_d;
    end
  end

  // datapath register, no reset
  logic [DW-1:0] wdata_r;
  logic [ADDR_W-1:0] addr_r;
  always_ff @(posedge clk) begin
    addr_r  <= addr;
    wdata_r <= wdata;
  end
  assign addr_q  = addr_r;
  assign wdata_q = wdata_r;
endmodule

// File: rtl/ssram_core.sv
module ssram_core #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_we,
  output logic [LANES*LANE_W-1:0] rdata_q
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] cur;
  logic [DW-1:0] merged;

  assign cur = mem[addr];

  // lane merge: one slice per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] =
      lane_we[g] ? wdata[g*LANE_W +: LANE_W] : cur[g*LANE_W +: LANE_W];
  end

  // self-timed commit at the edge after capture
  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= merged;
  end

  // pipelined read register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= cur;
  end
endmodule

// File: rtl/ssram_oe_pipe.sv
module ssram_oe_pipe
  import ssram_dcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ssram_cmd_t cmd_q,
  output logic       rd_en_q,
  output logic       hold_q,
  output logic       drive
);
  logic rd_en_d;
  logic hold_d;

  always_comb begin
    rd_en_d = cmd_q.rd;
    // extra enable stage: a deselect right after read data keeps the driver
    hold_d  = rd_en_q && cmd_q.desel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      rd_en_q <= rd_en_d;
      hold_q  <= hold_d;
    end
  end

  assign drive = rd_en_q || hold_q;
endmodule

// File: rtl/ssram_dcd_top.sv
module ssram_dcd_top
  import ssram_dcd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      cs_n,
  input  logic                      cs_hi,
  input  logic                      cs_lo_n,
  input  logic                      gwr_n,
  input  logic                      bwr_master_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic                      oe_n,
  input  logic                      snooze,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdata_oe
);
  localparam int DW = LANES * LANE_W;

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  ssram_cmd_t        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic [LANES-1:0]  lane_we_q;
  logic              rd_en_q;
  logic              hold_q;
  logic              drive;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  ssram_cmd_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) cmd_i (
    .clk(clk), .rst_n(rst_sync_n), .addr(addr), .wdata(wdata),
    .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .gwr_n(gwr_n),
    .bwr_master_n(bwr_master_n), .lane_wr_n(lane_wr_n), .snooze(snooze),
    .cmd_q(cmd_q), .addr_q(addr_q), .wdata_q(wdata_q), .lane_we_q(lane_we_q)
  );

  ssram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) core_i (
    .clk(clk), .rst_n(rst_sync_n), .wr(cmd_q.wr), .rd(cmd_q.rd),
    .addr(addr_q), .wdata(wdata_q), .lane_we(lane_we_q), .rdata_q(rdata)
  );

  ssram_oe_pipe oe_i (
    .clk(clk), .rst_n(rst_sync_n), .cmd_q(cmd_q),
    .rd_en_q(rd_en_q), .hold_q(hold_q), .drive(drive)
  );

  // asynchronous gating of the driver
  assign rdata_oe = drive && !oe_n && !snooze;
endmodule

// File: rtl/ssram_dcd_chk.sv
module ssram_dcd_chk
  import ssram_dcd_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic       snooze,
  input logic       oe_n,
  input logic       cs_n,
  input logic       rdata_oe,
  input ssram_cmd_t cmd_q,
  input logic       rd_en_q,
  input logic       hold_q
);
  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    oe_n |-> !rdata_oe);
  // R9
  snooze_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    snooze |-> !rdata_oe);
  // R9
  snooze_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(snooze) |-> !(cmd_q.rd || cmd_q.wr));
  // R6
  desel_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(cs_n) |-> !(cmd_q.rd || cmd_q.wr));
  // R2
  read_stage_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(cmd_q.rd) |-> rd_en_q);
  // R7
  dcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rd_en_q) && $past(cmd_q.desel)) |-> hold_q);
  // R7
  dcd_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(hold_q) |-> !hold_q);
  // R11
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(cmd_q.wr) |-> (!rd_en_q && !hold_q));
endmodule

bind ssram_dcd_top ssram_dcd_chk chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .snooze(snooze), .oe_n(oe_n),
  .cs_n(cs_n), .rdata_oe(rdata_oe), .cmd_q(cmd_q), .rd_en_q(rd_en_q),
  .hold_q(hold_q)
);

// File: tb/ssram_dcd_top_tb.sv
module ssram_dcd_top_tb_top;
  localparam int AW = 4;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          cs_n, cs_hi, cs_lo_n, gwr_n, bwr_master_n, oe_n, snooze;
  logic [1:0]    lane_wr_n;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] model [16];

  always #5 clk = ~clk;

  ssram_dcd_top dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .cs_n(cs_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .gwr_n(gwr_n),
    .bwr_master_n(bwr_master_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
    .snooze(snooze), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one command at a falling edge, return at the next falling edge
  task automatic cyc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [2:0] cs, input logic gw, input logic bwe,
                     input logic [1:0] bw, input logic zz);
    addr = a; wdata = d; {cs_n, cs_hi, cs_lo_n} = cs;
    gwr_n = gw; bwr_master_n = bwe; lane_wr_n = bw; snooze = zz;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cyc(a, '0, 3'b010, 1'b1, 1'b1, 2'b11, 1'b0);
  endtask
  task automatic gwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(a, d, 3'b010, 1'b0, 1'b1, 2'b11, 1'b0);
    model[a] = d;
  endtask
  task automatic idle();
    cyc('0, '0, 3'b110, 1'b1, 1'b1, 2'b11, 1'b0);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'((a * 7453 + s * 911 + 123) % (1 << DW));
  endfunction

  // read one address and check its data (issued then one idle)
  task automatic rd_chk(input logic [AW-1:0] a, input string tag);
    rd(a);
    idle();
    chk(rdata_oe === 1'b1 && rdata === model[a], tag,
        {rdata_oe, 13'd0, rdata}, {1'b1, 13'd0, model[a]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0;
    addr = '0; wdata = '0; {cs_n, cs_hi, cs_lo_n} = 3'b110;
    gwr_n = 1'b1; bwr_master_n = 1'b1; lane_wr_n = 2'b11; snooze = 1'b0;
    repeat (3) @(negedge clk);
    chk(rdata_oe === 1'b0, "R1 in reset", {31'd0, rdata_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdata_oe === 1'b0, "R1 after release", {31'd0, rdata_oe}, 0);

    // R4: fill via global write, R2: stream back
    for (int a = 0; a < 16; a++) gwr(AW'(a), pat(a, 0));
    rd('0);
    for (int a = 1; a < 16; a++) begin
      rd(AW'(a));
      chk(rdata_oe === 1'b1 && rdata === model[a-1], "R2 stream",
          {rdata_oe, 13'd0, rdata}, {1'b1, 13'd0, model[a-1]});
    end
    idle();
    chk(rdata === model[15] && rdata_oe === 1'b1, "R2 last",
        {14'd0, rdata}, {14'd0, model[15]});
    idle(); idle();

    // R3: each lane mask through the master qualifier
    for (int m = 0; m < 4; m++) begin
      logic [DW-1:0] d;
      d = pat(m, 7);
      cyc(4'd5, d, 3'b010, 1'b1, 1'b0, 2'(m), 1'b0);
      for (int l = 0; l < 2; l++)
        if (!m[l]) model[5][l*9 +: 9] = d[l*9 +: 9];
      rd_chk(4'd5, "R3 lane mask");
      idle();
    end
    // R4: global write overrides disabled lanes and qualifier
    cyc(4'd6, pat(6, 3), 3'b010, 1'b0, 1'b1, 2'b11, 1'b0);
    model[6] = pat(6, 3);
    rd_chk(4'd6, "R4 global no lanes");
    cyc(4'd6, pat(6, 4), 3'b010, 1'b0, 1'b0, 2'b10, 1'b0);
    model[6] = pat(6, 4);
    rd_chk(4'd6, "R4 global with lanes");
    idle();

    // R5: both write controls inactive with lane bits low reads
    cyc(4'd7, pat(7, 9), 3'b010, 1'b1, 1'b1, 2'b00, 1'b0);
    idle();
    chk(rdata_oe === 1'b1 && rdata === model[7], "R5 read with lanes low",
        {14'd0, rdata}, {14'd0, model[7]});
    idle();
    rd_chk(4'd7, "R5 word unchanged");
    idle();

    // R6: every non-selecting combination must not write
    for (int c = 0; c < 8; c++) begin
      if (c == 2) continue;
      cyc(4'd8, pat(c, 5), 3'(c), 1'b0, 1'b0, 2'b00, 1'b0);
      idle();
      chk(rdata_oe === 1'b0, "R6 no drive when deselected", {31'd0, rdata_oe}, 0);
      rd_chk(4'd8, "R6 no write when deselected");
      idle();
    end

    // R7: read then deselect: hold one cycle, then off
    rd(4'd9);
    idle();
    chk(rdata_oe === 1'b1 && rdata === model[9], "R7 first cycle",
        {14'd0, rdata}, {14'd0, model[9]});
    idle();
    chk(rdata_oe === 1'b1 && rdata === model[9], "R7 hold cycle",
        {rdata_oe, 13'd0, rdata}, {1'b1, 13'd0, model[9]});
    idle();
    chk(rdata_oe === 1'b0, "R7 off", {31'd0, rdata_oe}, 0);

    // R11: read then write: no hold
    rd(4'd9);
    gwr(4'd10, pat(10, 2));
    chk(rdata_oe === 1'b1, "R11 read data", {31'd0, rdata_oe}, 1);
    idle();
    chk(rdata_oe === 1'b0, "R11 no hold after write", {31'd0, rdata_oe}, 0);
    idle();

    // R10: write then read same address back to back
    gwr(4'd11, pat(11, 8));
    rd_chk(4'd11, "R10 read after write");
    idle();

    // R8: asynchronous output enable
    rd(4'd3);
    addr = 4'd0; {cs_n, cs_hi, cs_lo_n} = 3'b110;
    @(posedge clk); #2;
    chk(rdata_oe === 1'b1, "R8 on", {31'd0, rdata_oe}, 1);
    oe_n = 1'b1; #1;
    chk(rdata_oe === 1'b0, "R8 gated off", {31'd0, rdata_oe}, 0);
    oe_n = 1'b0; #1;
    chk(rdata_oe === 1'b1, "R8 restored", {31'd0, rdata_oe}, 1);
    @(negedge clk);
    idle(); idle();

    // R9: snooze gates driver and blocks a write
    rd(4'd3);
    addr = 4'd0; {cs_n, cs_hi, cs_lo_n} = 3'b110;
    @(posedge clk); #2;
    snooze = 1'b1; #1;
    chk(rdata_oe === 1'b0, "R9 driver off", {31'd0, rdata_oe}, 0);
    @(negedge clk);
    cyc(4'd3, ~model[3], 3'b010, 1'b0, 1'b0, 2'b00, 1'b1);
    cyc(4'd3, '0, 3'b010, 1'b1, 1'b1, 2'b11, 1'b1);
    snooze = 1'b0;
    idle(); idle();
    rd_chk(4'd3, "R9 write blocked");
    idle(); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule